// File: doc/BRIEF.md
# Memory Test Read-Data Error Checker

One channel of a memory test engine reads cachelines back from memory. Each line arrives as a series of beats ("chunks"). Every beat is 64 data bits plus 8 ECC bits, and a pattern generator supplies the data it expects for that beat. This checker compares each read beat with the expected beat and builds up sticky error status for each of the 72 lanes. It also counts failing events under a chosen counting mode. When the programmed stop condition is met, it raises a stop request toward the sequencer.

A single 32-bit control word programs the checker:

| Bits | Field |
|------|-------|
| [5:0] | threshold N for nth-error stopping |
| [13:12] | stop policy |
| [23:16] | chunk enable mask, indexed by chunk position |
| [31:24] | cacheline enable mask, indexed by cacheline number modulo 8 |

Two further masks take lanes out of checking: one covers the 64 data lanes and one covers the 8 ECC lanes. A clear input resets all status, counts and the stop request.

The checker is built around a three-state machine:
- ST_CLEAN: no error has been recorded.
- ST_FAILED: at least one error has been recorded, but no stop has been requested.
- ST_HALTED: a stop has been requested.

Transitions:
- CLEAN→FAILED: on a failing compared beat that does not meet the stop condition.
- CLEAN→HALTED and FAILED→HALTED: on a failing compared beat that meets the stop condition.
- Any state→CLEAN: on clear.

HALTED is left only through clear.

Top module: `mem_err_checker`

## Requirements
- R1: After reset, and in the cycle after `clear_errors` is high, `lane_err`, `ecc_err`, `err_count`, `any_error` and `stop_req` are all zero. Clear takes priority over a compare in the same cycle.
- R2: A beat is compared only if all three of the following hold:
  - `rd_valid` is high;
  - control bit 16+`chunk_idx` is set;
  - control bit 24+(`cl_idx` mod 8) is set.

  A beat that is not compared changes no output.
- R3: A data lane whose `data_mask` bit is set, or an ECC lane whose `ecc_mask` bit is set, is never flagged, whatever its data.
- R4: A lane is flagged in the cycle after a compared beat in which its read bit differs from its expected bit. The flag stays set until clear. Data lane i appears at `lane_err[i]` and ECC lane j at `ecc_err[j]`. `any_error` is high exactly when some lane flag is set.
- R5: `err_count` adds one per compared beat that produces an event of the selected `cnt_mode`, and saturates at all ones. The modes are:
  - 0 (per channel): any lane fails.
  - 1 (per lane): lane `cnt_sel` fails. Lanes 0–63 are data lanes and 64–71 are ECC lanes.
  - 2 (per byte group): any lane of group `cnt_sel` fails. Group g is lanes 8g..8g+7, and group 8 is the ECC byte.
  - 3 (per chunk): any lane fails on a beat whose `chunk_idx` equals `cnt_sel`.
- R6: With stop policy (control bits [13:12]) 0, `stop_req` never rises.
- R7: With policy 1, `stop_req` rises in the cycle after the compared beat that brings the count of failing beats since clear up to N (control bits [5:0]). N = 0 behaves as 1.
- R8: With policy 2, `stop_req` rises after a failing beat that leaves every byte group with at least one unmasked lane holding at least one flagged lane.
- R9: With policy 3, `stop_req` rises after a failing beat that leaves every unmasked lane flagged.
- R10: Once high, `stop_req` stays high, and lane flags and counts keep updating, until clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| clear_errors | input | 1 | clear all status, counts and stop |
| rd_valid | input | 1 | read beat valid |
| chunk_idx | input | 3 | chunk position of the beat within its cacheline |
| cl_idx | input | 8 | cacheline number of the beat |
| rd_data | input | 64 | returned read data |
| rd_ecc | input | 8 | returned ECC bits |
| exp_data | input | 64 | expected data |
| exp_ecc | input | 8 | expected ECC bits |
| err_ctl | input | 32 | control word |
| data_mask | input | 64 | data lanes excluded from checking |
| ecc_mask | input | 8 | ECC lanes excluded from checking |
| cnt_mode | input | 2 | counting mode |
| cnt_sel | input | 7 | lane, group or chunk selected for counting |
| any_error | output | 1 | some lane flagged |
| lane_err | output | 64 | sticky data-lane flags |
| ecc_err | output | 8 | sticky ECC-lane flags |
| err_count | output | 16 | saturating event count |
| stop_req | output | 1 | registered stop request |

## Verification
The bench targets several corner cases, and each one catches a specific kind of faulty design:

- **Cacheline enable index.** Beats use a cacheline number above 7 with the selected enable bit cleared. A design that indexed the enable mask by the full cacheline number would check these beats.
- **nth-error counting.** Failing, clean and failing beats are interleaved. A design that counted every compare, or stopped one beat early or late, would show `stop_req` in the wrong cycle. N = 0 is also exercised.
- **All-groups and all-lanes stop.** These run with the ECC byte fully masked, and with all but two lanes masked. A design that still demanded the masked lanes would never stop. One that forgot the sticky history would stop only when a single beat failed everywhere.
- **Clear, saturation and stop hold.** A clear arrives together with a failing beat and must win. The count is driven beyond its limit and must not wrap. The stop must hold through idle cycles.
- **Random runs.** Random runs mix all of these, with random masks and policies.

// File: rtl/mec_pkg.sv
package mec_pkg;

    typedef enum logic [1:0] {
        STOP_NEVER      = 2'd0,
        STOP_NTH        = 2'd1,
        STOP_ALL_GROUPS = 2'd2,
        STOP_ALL_LANES  = 2'd3
    } stop_pol_e;

    typedef enum logic [1:0] {
        CNT_CHANNEL = 2'd0,
        CNT_LANE    = 2'd1,
        CNT_GROUP   = 2'd2,
        CNT_CHUNK   = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'd0,
        ST_FAILED = 2'd1,
        ST_HALTED = 2'd2
    } chk_state_e;

    // Control word field positions, decoded by the programming side.
    localparam int NTH_LSB   = 0;
    localparam int NTH_W     = 6;
    localparam int POL_LSB   = 12;
    localparam int CHUNK_LSB = 16;
    localparam int CL_LSB    = 24;
    localparam int LANE_PER_GROUP = 8;

endpackage

// File: rtl/mec_beat_cmp.sv
module mec_beat_cmp #(
    parameter  int DATA_W   = 64,
    parameter  int ECC_W    = 8,
    parameter  int CHUNKS   = 8,
    parameter  int CLS      = 8,
    parameter  int CL_IDX_W = 8,
    localparam int LANES    = DATA_W + ECC_W,
    localparam int GROUPS   = LANES / mec_pkg::LANE_PER_GROUP,
    localparam int CHUNK_W  = $clog2(CHUNKS),
    localparam int CL_SEL_W = $clog2(CLS)
) (
    input  logic                rd_valid,
    input  logic [CHUNK_W-1:0]  chunk_idx,
    input  logic [CL_IDX_W-1:0] cl_idx,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic [DATA_W-1:0]   exp_data,
    input  logic [DATA_W-1:0]   data_mask,
    input  logic [ECC_W-1:0]    rd_ecc,
    input  logic [ECC_W-1:0]    exp_ecc,
    input  logic [ECC_W-1:0]    ecc_mask,
    input  logic [CHUNKS-1:0]   chunk_en,
    input  logic [CLS-1:0]      cl_en,
    output logic                check_en,
    output logic [LANES-1:0]    lane_fail,
    output logic [GROUPS-1:0]   group_fail,
    output logic [LANES-1:0]    req_lane,
    output logic [GROUPS-1:0]   req_group,
    output logic                beat_fail
);
    localparam int LPG = mec_pkg::LANE_PER_GROUP;

    logic [LANES-1:0] diff;

    always_comb begin
        check_en  = rd_valid && chunk_en[chunk_idx] && cl_en[cl_idx[CL_SEL_W-1:0]];
        req_lane  = ~{ecc_mask, data_mask};
        diff      = {rd_ecc, rd_data} ^ {exp_ecc, exp_data};
        lane_fail = check_en ? (diff & req_lane) : '0;
        beat_fail = |lane_fail;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign group_fail[g] = |lane_fail[g*LPG +: LPG];
        assign req_group[g]  = |req_lane[g*LPG +: LPG];
    end

endmodule

// File: rtl/mec_err_count.sv
module mec_err_count #(
    parameter  int LANES   = 72,
    parameter  int GROUPS  = 9,
    parameter  int CHUNKS  = 8,
    parameter  int CNT_W   = 16,
    parameter  int SEL_W   = 7,
    localparam int CHUNK_W = $clog2(CHUNKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                beat_fail,
    input  mec_pkg::cnt_mode_e  mode,
    input  logic [SEL_W-1:0]    sel,
    input  logic [LANES-1:0]    lane_fail,
    input  logic [GROUPS-1:0]   group_fail,
    input  logic [CHUNK_W-1:0]  chunk_idx,
    output logic [CNT_W-1:0]    count
);
    import mec_pkg::*;

    logic lane_hit, group_hit, chunk_hit, event_hit;

    always_comb begin
        lane_hit = 1'b0;
        for (int i = 0; i < LANES; i++)
            if (sel == SEL_W'(i)) lane_hit = lane_fail[i];
        group_hit = 1'b0;
        for (int i = 0; i < GROUPS; i++)
            if (sel == SEL_W'(i)) group_hit = group_fail[i];
        chunk_hit = 1'b0;
        for (int i = 0; i < CHUNKS; i++)
            if (sel == SEL_W'(i) && chunk_idx == CHUNK_W'(i)) chunk_hit = beat_fail;
        unique case (mode)
            CNT_CHANNEL: event_hit = beat_fail;
            CNT_LANE:    event_hit = lane_hit;
            CNT_GROUP:   event_hit = group_hit;
            CNT_CHUNK:   event_hit = chunk_hit;
            default:     event_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (event_hit && count != '1)
            count <= count + 1'b1;
    end

endmodule

// File: rtl/mec_stop_fsm.sv
module mec_stop_fsm #(
    parameter  int LANES  = 72,
    parameter  int GROUPS = 9,
    localparam int NTH_W  = mec_pkg::NTH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                beat_fail,
    input  logic [LANES-1:0]    lane_fail,
    input  logic [LANES-1:0]    req_lane,
    input  logic [GROUPS-1:0]   req_group,
    input  mec_pkg::stop_pol_e  policy,
    input  logic [NTH_W-1:0]    nth,
    output logic [LANES-1:0]    sticky,
    output logic                any_error,
    output logic                stop_req
);
    import mec_pkg::*;
    localparam int LPG = LANE_PER_GROUP;

    chk_state_e       state_q, state_d;
    logic [NTH_W-1:0] beats_q, beats_next, nth_eff;
    logic [LANES-1:0] sticky_q, lane_next;
    logic [GROUPS-1:0] grp_next;
    logic all_groups, all_lanes, nth_reached, trigger;

    always_comb begin
        lane_next = sticky_q | lane_fail;
        for (int g = 0; g < GROUPS; g++)
            grp_next[g] = |lane_next[g*LPG +: LPG];
        beats_next  = (beats_q == '1) ? beats_q : beats_q + 1'b1;
        nth_eff     = (nth == '0) ? NTH_W'(1) : nth;
        nth_reached = beats_next >= nth_eff;
        all_groups  = (|req_group) && ((grp_next & req_group) == req_group);
        all_lanes   = (|req_lane) && ((lane_next & req_lane) == req_lane);
        unique case (policy)
            STOP_NEVER:      trigger = 1'b0;
            STOP_NTH:        trigger = nth_reached;
            STOP_ALL_GROUPS: trigger = all_groups;
            STOP_ALL_LANES:  trigger = all_lanes;
            default:         trigger = 1'b0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN:  if (beat_fail) state_d = trigger ? ST_HALTED : ST_FAILED;
            ST_FAILED: if (beat_fail && trigger) state_d = ST_HALTED;
            ST_HALTED: state_d = ST_HALTED;
            default:   state_d = ST_CLEAN;
        endcase
        if (clear) state_d = ST_CLEAN;
    end

    // State register and tracked history
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state_q  <= ST_CLEAN;
            sticky_q <= '0;
            beats_q  <= '0;
        end else begin
            state_q <= state_d;
            if (beat_fail) begin
                sticky_q <= lane_next;
                beats_q  <= beats_next;
            end
        end
    end

    // Outputs from state
    always_comb begin
        sticky    = sticky_q;
        any_error = (state_q != ST_CLEAN);
        stop_req  = (state_q == ST_HALTED);
    end

endmodule

// File: rtl/mem_err_checker.sv
module mem_err_checker #(
    parameter  int DATA_W   = 64,
    parameter  int ECC_W    = 8,
    parameter  int CHUNKS   = 8,
    parameter  int CLS      = 8,
    parameter  int CL_IDX_W = 8,
    parameter  int CNT_W    = 16,
    localparam int LANES    = DATA_W + ECC_W,
    localparam int GROUPS   = LANES / 8,
    localparam int CHUNK_W  = $clog2(CHUNKS),
    localparam int SEL_W    = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_errors,
    input  logic                rd_valid,
    input  logic [CHUNK_W-1:0]  chunk_idx,
    input  logic [CL_IDX_W-1:0] cl_idx,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic [ECC_W-1:0]    rd_ecc,
    input  logic [DATA_W-1:0]   exp_data,
    input  logic [ECC_W-1:0]    exp_ecc,
    input  logic [31:0]         err_ctl,
    input  logic [DATA_W-1:0]   data_mask,
    input  logic [ECC_W-1:0]    ecc_mask,
    input  logic [1:0]          cnt_mode,
    input  logic [SEL_W-1:0]    cnt_sel,
    output logic                any_error,
    output logic [DATA_W-1:0]   lane_err,
    output logic [ECC_W-1:0]    ecc_err,
    output logic [CNT_W-1:0]    err_count,
    output logic                stop_req
);
    import mec_pkg::*;

    logic              check_en, beat_fail;
    logic [LANES-1:0]  lane_fail, req_lane, sticky;
    logic [GROUPS-1:0] group_fail, req_group;
    stop_pol_e         policy;
    cnt_mode_e         mode;

    assign policy = stop_pol_e'(err_ctl[POL_LSB +: 2]);
    assign mode   = cnt_mode_e'(cnt_mode);

    mec_beat_cmp #(
        .DATA_W(DATA_W), .ECC_W(ECC_W), .CHUNKS(CHUNKS),
        .CLS(CLS), .CL_IDX_W(CL_IDX_W)
    ) u_cmp (
        .rd_valid   (rd_valid),
        .chunk_idx  (chunk_idx),
        .cl_idx     (cl_idx),
        .rd_data    (rd_data),
        .exp_data   (exp_data),
        .data_mask  (data_mask),
        .rd_ecc     (rd_ecc),
        .exp_ecc    (exp_ecc),
        .ecc_mask   (ecc_mask),
        .chunk_en   (err_ctl[CHUNK_LSB +: CHUNKS]),
        .cl_en      (err_ctl[CL_LSB +: CLS]),
        .check_en   (check_en),
        .lane_fail  (lane_fail),
        .group_fail (group_fail),
        .req_lane   (req_lane),
        .req_group  (req_group),
        .beat_fail  (beat_fail)
    );

    mec_err_count #(
        .LANES(LANES), .GROUPS(GROUPS), .CHUNKS(CHUNKS),
        .CNT_W(CNT_W), .SEL_W(SEL_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_errors),
        .beat_fail  (beat_fail),
        .mode       (mode),
        .sel        (cnt_sel),
        .lane_fail  (lane_fail),
        .group_fail (group_fail),
        .chunk_idx  (chunk_idx),
        .count      (err_count)
    );

    mec_stop_fsm #(
        .LANES(LANES), .GROUPS(GROUPS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_errors),
        .beat_fail (beat_fail),
        .lane_fail (lane_fail),
        .req_lane  (req_lane),
        .req_group (req_group),
        .policy    (policy),
        .nth       (err_ctl[NTH_LSB +: NTH_W]),
        .sticky    (sticky),
        .any_error (any_error),
        .stop_req  (stop_req)
    );

    assign lane_err = sticky[DATA_W-1:0];
    assign ecc_err  = sticky[LANES-1:DATA_W];

endmodule

// File: rtl/mec_checker.sv
module mec_checker #(
    parameter int DATA_W = 64,
    parameter int ECC_W  = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_errors,
    input logic              rd_valid,
    input logic [31:0]       err_ctl,
    input logic              beat_fail,
    input logic              any_error,
    input logic [DATA_W-1:0] lane_err,
    input logic [ECC_W-1:0]  ecc_err,
    input logic [CNT_W-1:0]  err_count,
    input logic              stop_req
);
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_errors |=> (!any_error && !stop_req && err_count == '0 && lane_err == '0 && ecc_err == '0)); // R1
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && !clear_errors) |=> ($stable(lane_err) && $stable(ecc_err) && $stable(err_count))); // R2
    AST_STICKY_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_errors |=> (($past(lane_err) & ~lane_err) == '0 && ($past(ecc_err) & ~ecc_err) == '0)); // R4
    AST_ANY_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        any_error == ((|lane_err) || (|ecc_err))); // R4
    AST_NEVER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ctl[13:12] == 2'd0 && !stop_req) |=> !stop_req); // R6
    AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_req) |-> $past(beat_fail)); // R7
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !clear_errors) |=> stop_req); // R10
endmodule

bind mem_err_checker mec_checker #(.DATA_W(DATA_W), .ECC_W(ECC_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_errors (clear_errors),
    .rd_valid     (rd_valid),
    .err_ctl      (err_ctl),
    .beat_fail    (beat_fail),
    .any_error    (any_error),
    .lane_err     (lane_err),
    .ecc_err      (ecc_err),
    .err_count    (err_count),
    .stop_req     (stop_req)
);

// File: tb/sim_mem_err_checker.sv
module sim_mem_err_checker;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 4;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n, clr, vld;
    logic [2:0]  chk;
    logic [7:0]  cl;
    logic [63:0] rdd, exd, dm;
    logic [7:0]  rde, exe, em;
    logic [31:0] ctl;
    logic [1:0]  mode;
    logic [6:0]  sel;
    logic        any_error, stop_req;
    logic [63:0] lane_err;
    logic [7:0]  ecc_err;
    logic [CNT_W-1:0] err_count;

    logic [71:0] m_st;
    int m_cnt, m_beats;
    bit m_stop;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_err_checker #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .clear_errors(clr), .rd_valid(vld),
        .chunk_idx(chk), .cl_idx(cl), .rd_data(rdd), .rd_ecc(rde),
        .exp_data(exd), .exp_ecc(exe), .err_ctl(ctl), .data_mask(dm),
        .ecc_mask(em), .cnt_mode(mode), .cnt_sel(sel),
        .any_error(any_error), .lane_err(lane_err), .ecc_err(ecc_err),
        .err_count(err_count), .stop_req(stop_req)
    );

    task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    function automatic bit stop_rule(input logic [71:0] nxt, input logic [71:0] rq, input int beats);
        logic [8:0] gn, gr;
        int neff;
        for (int g = 0; g < 9; g++) begin
            gn[g] = |nxt[g*8 +: 8];
            gr[g] = |rq[g*8 +: 8];
        end
        neff = (ctl[5:0] == 0) ? 1 : int'(ctl[5:0]);
        case (ctl[13:12])
            2'd1: return beats >= neff;
            2'd2: return (gr != 0) && ((gn & gr) == gr);
            2'd3: return (rq != 0) && ((nxt & rq) == rq);
            default: return 1'b0;
        endcase
    endfunction

    // Apply current inputs for one clock, update the model, sample at negedge.
    task automatic tick();
        logic [71:0] f, rq;
        bit en, hit;
        if (clr) begin
            m_st = '0; m_cnt = 0; m_beats = 0; m_stop = 0;
        end else begin
            en = vld && ctl[16 + chk] && ctl[24 + (cl % 8)];
            rq = ~{em, dm};
            f  = en ? (({rde, rdd} ^ {exe, exd}) & rq) : '0;
            if (f != 0) begin
                case (mode)
                    2'd0: hit = 1;
                    2'd1: hit = (sel < 72) && f[sel];
                    2'd2: hit = (sel < 9) && (|f[sel*8 +: 8]);
                    default: hit = (sel < 8) && (chk == sel[2:0]);
                endcase
                if (hit && m_cnt < CNT_MAX) m_cnt++;
                m_beats = (m_beats < 63) ? m_beats + 1 : 63;
                if (stop_rule(m_st | f, rq, m_beats)) m_stop = 1;
                m_st = m_st | f;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(lane_err === m_st[63:0], "R4 lane_err", 72'(lane_err), 72'(m_st[63:0]));
        check(ecc_err === m_st[71:64], "R3 ecc_err", 72'(ecc_err), 72'(m_st[71:64]));
        check(err_count === CNT_W'(m_cnt), "R5 err_count", 72'(err_count), 72'(m_cnt));
        check(stop_req === m_stop, "R10 stop_req", 72'(stop_req), 72'(m_stop));
        check(any_error === (m_st != 0), "R4 any_error", 72'(any_error), 72'(m_st != 0));
    endtask

    task automatic beat(input logic [71:0] errs);
        exd = {$urandom, $urandom};
        exe = 8'($urandom);
        rdd = exd ^ errs[63:0];
        rde = exe ^ errs[71:64];
        vld = 1;
        tick();
        vld = 0;
    endtask

    task automatic do_clear();
        clr = 1; vld = 0;
        tick();
        clr = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(1234));
        rst_n = 0; clr = 0; vld = 0; chk = 0; cl = 0;
        rdd = 0; exd = 0; rde = 0; exe = 0; dm = 0; em = 0;
        ctl = 32'hFFFF_0000; mode = 0; sel = 0;
        m_st = 0; m_cnt = 0; m_beats = 0; m_stop = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check({lane_err, ecc_err, err_count, any_error, stop_req} == 0, "R1 reset state",
              72'({lane_err, ecc_err}), 72'(0));

        // R2 gating
        rdd = 64'h20; exd = 0; vld = 0; tick();
        check(lane_err == 0, "R2 invalid beat ignored", 72'(lane_err), 72'(0));
        chk = 2; ctl = 32'hFFFB_0000; beat(72'h20);
        check(lane_err == 0, "R2 chunk disabled", 72'(lane_err), 72'(0));
        ctl = 32'hFDFF_0000; cl = 8'd9; beat(72'h20);
        check(lane_err == 0 && !any_error, "R2 cacheline 9 uses enable bit 1", 72'(lane_err), 72'(0));
        ctl = 32'hFFFF_0000; beat(72'h20);
        check(lane_err == 64'h20, "R2 enabled beat compared", 72'(lane_err), 72'h20);
        do_clear();
        check(lane_err == 0 && !any_error && err_count == 0, "R1 clear", 72'(lane_err), 72'(0));

        // R3 masks
        dm = 64'h80; em = 8'h04; beat((72'h1 << 7) | (72'h1 << 8) | (72'h1 << 66) | (72'h1 << 67));
        check(lane_err == 64'h100, "R3 data mask", 72'(lane_err), 72'h100);
        check(ecc_err == 8'h08, "R3 ecc mask", 72'(ecc_err), 72'h08);
        dm = 0; em = 0; do_clear();

        // R5 counting modes
        mode = 1; sel = 8;
        beat(72'h1 << 8); beat(72'h1 << 9); beat((72'h1 << 8) | (72'h1 << 9));
        check(err_count == 2, "R5 per-lane count", 72'(err_count), 72'(2));
        do_clear();
        mode = 2; sel = 8;
        beat(72'h1 << 65); beat(72'h1 << 3); beat(72'h1 << 70);
        check(err_count == 2, "R5 per-group count", 72'(err_count), 72'(2));
        do_clear();
        mode = 3; sel = 5;
        chk = 5; beat(72'h1); chk = 4; beat(72'h1); chk = 5; beat(72'h0);
        check(err_count == 1, "R5 per-chunk count", 72'(err_count), 72'(1));
        do_clear();
        mode = 0; chk = 0;
        for (int i = 0; i < 20; i++) beat(72'h2);
        check(err_count == CNT_W'(CNT_MAX), "R5 saturation", 72'(err_count), 72'(CNT_MAX));
        do_clear();

        // R6 never stop
        ctl = 32'hFFFF_0000;
        for (int i = 0; i < 10; i++) beat({72{1'b1}});
        check(!stop_req, "R6 policy 0", 72'(stop_req), 72'(0));
        do_clear();

        // R7 nth error
        ctl = 32'hFFFF_1003;
        beat(72'h4); beat(72'h0); beat(72'h4);
        check(!stop_req, "R7 before nth", 72'(stop_req), 72'(0));
        beat(72'h8);
        check(stop_req, "R7 at nth", 72'(stop_req), 72'(1));
        do_clear();
        ctl = 32'hFFFF_1000; beat(72'h1);
        check(stop_req, "R7 N=0 as 1", 72'(stop_req), 72'(1));
        do_clear();

        // R8 all byte groups, ECC byte masked
        ctl = 32'hFFFF_2000; em = 8'hFF;
        for (int g = 0; g < 7; g++) beat(72'h1 << (g*8 + g));
        check(!stop_req, "R8 seven groups", 72'(stop_req), 72'(0));
        beat(72'h1 << 60);
        check(stop_req, "R8 all groups", 72'(stop_req), 72'(1));
        em = 0; do_clear();

        // R9 all lanes, two lanes unmasked
        ctl = 32'hFFFF_3000; em = 8'hFF; dm = ~((64'h1) | (64'h1 << 40));
        beat(72'h1); beat(72'h1);
        check(!stop_req, "R9 one lane", 72'(stop_req), 72'(0));
        beat(72'h1 << 40);
        check(stop_req, "R9 all lanes", 72'(stop_req), 72'(1));

        // R10 hold and clear priority
        tick(); tick(); tick();
        check(stop_req, "R10 stop held", 72'(stop_req), 72'(1));
        clr = 1; beat(72'h1); clr = 0;
        check(!stop_req && lane_err == 0, "R10 clear wins", 72'(lane_err), 72'(0));
        em = 0; dm = 0;

        // Random runs
        for (int seg = 0; seg < 20; seg++) begin
            do_clear();
            ctl = {8'($urandom) | 8'h0F, 8'($urandom) | 8'hF0, 2'b00, 2'($urandom), 6'b0, 6'($urandom_range(0, 8))};
            mode = 2'($urandom);
            sel = 7'($urandom_range(0, 9));
            if (ctl[13:12] == 2'd3) begin
                dm = ~(64'h1 << $urandom_range(0, 63)); em = 8'hFF;
            end else begin
                dm = ($urandom_range(0, 3) == 0) ? {$urandom, $urandom} : 64'h0;
                em = 8'($urandom);
            end
            for (int b = 0; b < 150; b++) begin
                chk = 3'($urandom);
                cl = 8'($urandom);
                if ($urandom_range(0, 9) < 3)
                    beat(72'h1 << $urandom_range(0, 71));
                else if ($urandom_range(0, 9) == 0)
                    tick();
                else
                    beat(72'h0);
            end
        end
        finish_run();
    end
endmodule